// File: doc/BRIEF.md
# Paced Block Transfer Engine

This controller-side engine moves a block of words between a module port and a host-side valid/ready stream. A single start command loads the whole job: word count, direction, whether the module sub-address advances per word, the pacing mode, a base address and a handshake timeout. After that, no command is exchanged per word. The block streams until it is complete, a checksum word closes it, and the engine reports completion or an error.

Every transfer runs through three phases in order: setup on the start command, streaming of the data words, and termination with the checksum word. Pacing comes in two forms. In synchronous mode the engine moves one word on every clock. In asynchronous mode a word moves only in a cycle where the module raises its ready line. In both modes a stall from the host holds the engine without dropping a word. For reads from the module, the engine checks the trailing checksum word that the module supplies against its own running sum. For writes to the module, the engine computes the checksum word and sends it.

Top module: `blk_xfer_engine`

## Requirements
- R1: A start is accepted only while `busy` is low. It latches length, direction, increment mode, pacing mode, base address and timeout. A start raised while busy has no effect. `busy` is high from the cycle after an accepted non-zero start until the `done` cycle. An accepted block moves exactly `cfg_len` data words plus one checksum word.
- R2: A start with `cfg_len` = 0 sets `err_cfg`. It leaves `busy` low and produces no module strobe and no `done`.
- R3: With `cfg_inc`=1, data word i is strobed at address `cfg_base`+i modulo 2^ADDR_W, and the checksum word at `cfg_base`+`cfg_len`. With `cfg_inc`=0, every word uses `cfg_base`.
- R4: With `cfg_async`=1, `mod_strobe` is high only in cycles where `mod_ready` is high.
- R5: With `cfg_async`=0 and no host stall, the data words and the checksum word are strobed in `cfg_len`+1 consecutive cycles.
- R6: With `cfg_dir`=0 (module to host), the data words appear on the host output stream in order, each exactly once, under any pattern of `hs_out_ready`. A word held with `hs_out_ready` low stays unchanged.
- R7: With `cfg_dir`=1 (host to module), each host word accepted by a handshake is strobed to the module with its data, in order. `hs_in_ready` is high only when pacing permits.
- R8: With `cfg_dir`=0, the word read after the last data word is compared with the modulo-2^DATA_W sum of the data words. It is not forwarded to the host, and a mismatch sets `err_cksum`.
- R9: With `cfg_dir`=1, the word after the last data word carries `mod_cksum`=1 and the modulo-2^DATA_W sum of the data words.
- R10: In asynchronous mode, if `mod_ready` stays low for `cfg_timeout` consecutive cycles while the engine is waiting for a word, the transfer aborts. `err_timeout` is set and `done` follows two cycles after the last waiting cycle.
- R11: `done` is a one-cycle pulse that comes only after the last host-bound word has been taken. `busy` is low in that cycle.
- R12: `err_cfg`, `err_cksum` and `err_timeout` hold their value until the next accepted start, which clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start command |
| cfg_len | input | LEN_W | Data words in the block |
| cfg_dir | input | 1 | 0: module to host, 1: host to module |
| cfg_inc | input | 1 | 1: advance sub-address per word |
| cfg_async | input | 1 | 1: ready-paced, 0: one word per clock |
| cfg_base | input | ADDR_W | First module sub-address |
| cfg_timeout | input | TMO_W | Ready wait limit in cycles |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| err_cfg | output | 1 | Zero-length start seen |
| err_cksum | output | 1 | Checksum mismatch on read |
| err_timeout | output | 1 | Ready wait aborted |
| mod_addr | output | ADDR_W | Module sub-address |
| mod_strobe | output | 1 | A word moves this cycle |
| mod_write | output | 1 | Direction of the strobed word |
| mod_cksum | output | 1 | Strobed word is the checksum |
| mod_wdata | output | DATA_W | Word sent to module |
| mod_rdata | input | DATA_W | Word from module |
| mod_ready | input | 1 | Module ready for asynchronous pacing |
| hs_out_valid | output | 1 | Host output word valid |
| hs_out_data | output | DATA_W | Host output word |
| hs_out_ready | input | 1 | Host accepts output word |
| hs_in_valid | input | 1 | Host input word valid |
| hs_in_data | input | DATA_W | Host input word |
| hs_in_ready | output | 1 | Engine accepts input word |

## Verification
The output holding register can be emptied by the host and refilled by the module in the same cycle. Likewise, the last data word can still sit in it while the checksum word is taken. Both cases come up when `hs_out_ready` and `mod_ready` are driven by independent random draws, in both pacing modes. They are judged by matching the host word sequence against the bench pattern, by a stability property on a stalled word, and by requiring `done` only after the final word is taken.

// File: rtl/blk_xfer_pkg.sv
// Shared types of the block transfer engine.
// Assumes: nothing beyond the four transfer phases listed here.
package blk_xfer_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DATA  = 2'd1,
        ST_CKSUM = 2'd2,
        ST_FIN   = 2'd3
    } xfer_state_t;
endpackage

// File: rtl/btx_pacer.sv
// Pacing gate and ready-wait timeout for one transfer.
// Assumes: 'want' is high only while the engine can take a word, so that
// host stalls never count as module wait cycles.
module btx_pacer #(
    parameter int unsigned TMO_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             async_mode,
    input  logic             want,
    input  logic             mod_ready,
    input  logic [TMO_W-1:0] limit,
    output logic             pace_ok,
    output logic             expire
);
    localparam int unsigned CNT_W = TMO_W + 1;

    logic [TMO_W-1:0] wait_q;
    logic [CNT_W-1:0] next_cnt;
    logic             waiting;

    assign pace_ok  = !async_mode || mod_ready;
    assign waiting  = active && async_mode && want && !mod_ready;
    assign next_cnt = {1'b0, wait_q} + 1'b1;
    assign expire   = waiting && (next_cnt >= {1'b0, limit});

    // Count consecutive wait cycles; any non-waiting cycle restarts the count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wait_q <= '0;
        end else if (waiting && !expire) begin
            wait_q <= next_cnt[TMO_W-1:0];
        end else begin
            wait_q <= '0;
        end
    end
endmodule

// File: rtl/btx_walker.sv
// Remaining-word counter and module sub-address generator.
// Assumes: 'load' and 'step' are never high together.
module btx_walker #(
    parameter int unsigned LEN_W  = 12,
    parameter int unsigned ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [LEN_W-1:0]  len,
    input  logic [ADDR_W-1:0] base,
    input  logic              inc,
    input  logic              step,
    output logic [ADDR_W-1:0] addr,
    output logic              last
);
    localparam logic [LEN_W-1:0] ONE_WORD = LEN_W'(1);

    logic [LEN_W-1:0]  remain_q;
    logic [ADDR_W-1:0] addr_q;
    logic              inc_q;

    assign addr = addr_q;
    assign last = (remain_q == ONE_WORD);

    // Load the job on start, then count down and advance per data word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_q <= '0;
            addr_q   <= '0;
            inc_q    <= 1'b0;
        end else if (load) begin
            remain_q <= len;
            addr_q   <= base;
            inc_q    <= inc;
        end else if (step) begin
            remain_q <= remain_q - ONE_WORD;
            if (inc_q) begin
                addr_q <= addr_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/btx_sum.sv
// Running modulo-2^DATA_W sum of the data words of one block.
// Assumes: 'clear' comes with the accepted start, before any 'add'.
module btx_sum #(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              add,
    input  logic [DATA_W-1:0] word,
    output logic [DATA_W-1:0] sum
);
    logic [DATA_W-1:0] sum_q;

    assign sum = sum_q;

    // Accumulate each moved data word, wrapping at the word width.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_q <= '0;
        end else if (clear) begin
            sum_q <= '0;
        end else if (add) begin
            sum_q <= sum_q + word;
        end
    end
endmodule

// File: rtl/blk_xfer_engine.sv
// Block transfer engine: setup on start, streaming of the data words with
// clock or ready pacing, then termination with a checksum word.
// Assumes: the module drives mod_rdata for the word at mod_addr in any cycle
// a read strobe can occur; the host stream follows valid/ready rules.
module blk_xfer_engine
    import blk_xfer_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned ADDR_W = 5,
    parameter int unsigned LEN_W  = 12,
    parameter int unsigned TMO_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic              cfg_dir,
    input  logic              cfg_inc,
    input  logic              cfg_async,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [TMO_W-1:0]  cfg_timeout,
    output logic              busy,
    output logic              done,
    output logic              err_cfg,
    output logic              err_cksum,
    output logic              err_timeout,
    output logic [ADDR_W-1:0] mod_addr,
    output logic              mod_strobe,
    output logic              mod_write,
    output logic              mod_cksum,
    output logic [DATA_W-1:0] mod_wdata,
    input  logic [DATA_W-1:0] mod_rdata,
    input  logic              mod_ready,
    output logic              hs_out_valid,
    output logic [DATA_W-1:0] hs_out_data,
    input  logic              hs_out_ready,
    input  logic              hs_in_valid,
    input  logic [DATA_W-1:0] hs_in_data,
    output logic              hs_in_ready
);
    localparam logic [LEN_W-1:0] NO_WORDS = '0;

    xfer_state_t       st_q;
    logic              dir_q, async_q, inc_q;
    logic [TMO_W-1:0]  tmo_q;
    logic              done_q, err_cfg_q, err_cks_q, err_tmo_q;
    logic              ovalid_q;
    logic [DATA_W-1:0] odata_q;

    logic              accept, load, active, in_data_phase, in_cks_phase;
    logic              want, pace_ok, expire, fire, data_fire, last_word;
    logic [DATA_W-1:0] sum, data_word;

    assign accept        = start && (st_q == ST_IDLE);
    assign load          = accept && (cfg_len != NO_WORDS);
    assign in_data_phase = (st_q == ST_DATA);
    assign in_cks_phase  = (st_q == ST_CKSUM);
    assign active        = in_data_phase || in_cks_phase;

    // Decide whether the engine can take a word this cycle, ignoring pacing.
    always_comb begin
        want = 1'b0;
        if (in_cks_phase) begin
            want = 1'b1;
        end else if (in_data_phase) begin
            want = dir_q ? hs_in_valid : (!ovalid_q || hs_out_ready);
        end
    end

    assign fire      = active && want && pace_ok;
    assign data_fire = fire && in_data_phase;
    assign data_word = dir_q ? hs_in_data : mod_rdata;

    btx_pacer #(.TMO_W(TMO_W)) pacer_i (
        .clk(clk), .rst_n(rst_n), .active(active), .async_mode(async_q),
        .want(want), .mod_ready(mod_ready), .limit(tmo_q),
        .pace_ok(pace_ok), .expire(expire)
    );

    btx_walker #(.LEN_W(LEN_W), .ADDR_W(ADDR_W)) walker_i (
        .clk(clk), .rst_n(rst_n), .load(load), .len(cfg_len), .base(cfg_base),
        .inc(cfg_inc), .step(data_fire), .addr(mod_addr), .last(last_word)
    );

    btx_sum #(.DATA_W(DATA_W)) sum_i (
        .clk(clk), .rst_n(rst_n), .clear(load), .add(data_fire),
        .word(data_word), .sum(sum)
    );

    // Phase sequencing, latched job settings, sticky errors and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= ST_IDLE;
            dir_q     <= 1'b0;
            async_q   <= 1'b0;
            inc_q     <= 1'b0;
            tmo_q     <= '0;
            done_q    <= 1'b0;
            err_cfg_q <= 1'b0;
            err_cks_q <= 1'b0;
            err_tmo_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (st_q)
                ST_IDLE: begin
                    if (accept) begin
                        err_cfg_q <= (cfg_len == NO_WORDS);
                        err_cks_q <= 1'b0;
                        err_tmo_q <= 1'b0;
                        if (load) begin
                            st_q    <= ST_DATA;
                            dir_q   <= cfg_dir;
                            async_q <= cfg_async;
                            inc_q   <= cfg_inc;
                            tmo_q   <= cfg_timeout;
                        end
                    end
                end
                ST_DATA: begin
                    if (expire) begin
                        err_tmo_q <= 1'b1;
                        st_q      <= ST_FIN;
                    end else if (fire && last_word) begin
                        st_q <= ST_CKSUM;
                    end
                end
                ST_CKSUM: begin
                    if (expire) begin
                        err_tmo_q <= 1'b1;
                        st_q      <= ST_FIN;
                    end else if (fire) begin
                        st_q <= ST_FIN;
                        if (!dir_q && (mod_rdata != sum)) begin
                            err_cks_q <= 1'b1;
                        end
                    end
                end
                ST_FIN: begin
                    if (!ovalid_q) begin
                        st_q   <= ST_IDLE;
                        done_q <= 1'b1;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // One-word host output register: refilled by the module, drained by the host.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovalid_q <= 1'b0;
            odata_q  <= '0;
        end else if (data_fire && !dir_q) begin
            ovalid_q <= 1'b1;
            odata_q  <= mod_rdata;
        end else if (hs_out_ready) begin
            ovalid_q <= 1'b0;
        end
    end

    assign busy         = (st_q != ST_IDLE);
    assign done         = done_q;
    assign err_cfg      = err_cfg_q;
    assign err_cksum    = err_cks_q;
    assign err_timeout  = err_tmo_q;
    assign mod_strobe   = fire;
    assign mod_write    = dir_q;
    assign mod_cksum    = in_cks_phase;
    assign mod_wdata    = in_cks_phase ? sum : hs_in_data;
    assign hs_out_valid = ovalid_q;
    assign hs_out_data  = odata_q;
    assign hs_in_ready  = in_data_phase && dir_q && pace_ok;
endmodule

// File: rtl/btx_checker.sv
// Protocol properties of the block transfer engine, bound to its top.
// Assumes: async_q, inc_q and streaming reflect the latched job and phase.
module btx_checker #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned ADDR_W = 5,
    parameter int unsigned LEN_W  = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [LEN_W-1:0]  cfg_len,
    input logic              busy,
    input logic              done,
    input logic              err_cfg,
    input logic              mod_strobe,
    input logic              mod_ready,
    input logic [ADDR_W-1:0] mod_addr,
    input logic              async_q,
    input logic              inc_q,
    input logic              streaming,
    input logic              hs_out_valid,
    input logic              hs_out_ready,
    input logic [DATA_W-1:0] hs_out_data,
    input logic              hs_in_ready
);
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mod_strobe && !hs_in_ready));

    assert_zero_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && (cfg_len == '0)) |=> (!busy && err_cfg));

    assert_addr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_strobe && streaming && !inc_q) |=> (mod_addr == $past(mod_addr)));

    assert_addr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_strobe && streaming && inc_q) |=> (mod_addr == ($past(mod_addr) + 1'b1)));

    assert_async_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && async_q && mod_strobe) |-> mod_ready);

    assert_word_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_out_valid && !hs_out_ready) |=> (hs_out_valid && $stable(hs_out_data)));

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
endmodule

bind blk_xfer_engine btx_checker #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_len(cfg_len),
    .busy(busy), .done(done), .err_cfg(err_cfg),
    .mod_strobe(mod_strobe), .mod_ready(mod_ready), .mod_addr(mod_addr),
    .async_q(async_q), .inc_q(inc_q), .streaming(in_data_phase),
    .hs_out_valid(hs_out_valid), .hs_out_ready(hs_out_ready),
    .hs_out_data(hs_out_data), .hs_in_ready(hs_in_ready)
);

// File: tb/blk_xfer_engine_tb_top.sv
`timescale 1ns/1ps
module blk_xfer_engine_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [11:0] cfg_len = '0;
    logic        cfg_dir = 1'b0, cfg_inc = 1'b0, cfg_async = 1'b0;
    logic [4:0]  cfg_base = '0;
    logic [7:0]  cfg_timeout = '0;
    logic        busy, done, err_cfg, err_cksum, err_timeout;
    logic [4:0]  mod_addr;
    logic        mod_strobe, mod_write, mod_cksum;
    logic [15:0] mod_wdata;
    logic [15:0] mod_rdata = '0;
    logic        mod_ready = 1'b0;
    logic        hs_out_valid;
    logic [15:0] hs_out_data;
    logic        hs_out_ready = 1'b0;
    logic        hs_in_valid = 1'b0;
    logic [15:0] hs_in_data = '0;
    logic        hs_in_ready;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    blk_xfer_engine dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_len(cfg_len),
        .cfg_dir(cfg_dir), .cfg_inc(cfg_inc), .cfg_async(cfg_async),
        .cfg_base(cfg_base), .cfg_timeout(cfg_timeout), .busy(busy),
        .done(done), .err_cfg(err_cfg), .err_cksum(err_cksum),
        .err_timeout(err_timeout), .mod_addr(mod_addr), .mod_strobe(mod_strobe),
        .mod_write(mod_write), .mod_cksum(mod_cksum), .mod_wdata(mod_wdata),
        .mod_rdata(mod_rdata), .mod_ready(mod_ready),
        .hs_out_valid(hs_out_valid), .hs_out_data(hs_out_data),
        .hs_out_ready(hs_out_ready), .hs_in_valid(hs_in_valid),
        .hs_in_data(hs_in_data), .hs_in_ready(hs_in_ready)
    );

    function automatic logic [15:0] pat(input logic [15:0] seed, input int i);
        logic [31:0] v;
        v = (32'(i) + 32'd1) * 32'd40503 ^ (32'(seed) * 32'd7919) ^ (32'(i) << 5);
        return v[15:0];
    endfunction

    function automatic logic [15:0] cks(input logic [15:0] seed, input int len);
        logic [15:0] s = '0;
        for (int i = 0; i < len; i++) s = s + pat(seed, i);
        return s;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    endtask

    // One transfer with per-cycle stimulus; checks computed from the requirements.
    task automatic run_xfer(input int len, input bit dir, input bit inc, input bit asy,
                            input logic [4:0] base, input logic [7:0] tmo,
                            input logic [15:0] seed, input bit corrupt,
                            input int rdy_pct, input int ordy_pct, input int ival_pct,
                            input bit hold_low, input bit poke);
        int midx = 0, oidx = 0, iidx = 0;
        int addr_bad = 0, data_bad = 0, nrdy = 0, busy_bad = 0, cks_bad = 0;
        int done_cnt = 0, done_cyc = -1, first_s = -1, last_s = -1;
        logic flags_c1 = 1'b0;
        logic [15:0] esum = cks(seed, len);
        for (int c = 0; c < 6000; c++) begin
            @(negedge clk);
            start       = (c == 0) || (poke && c == 3);
            cfg_len     = (poke && c == 3) ? 12'(len + 7) : 12'(len);
            cfg_dir     = dir;
            cfg_inc     = inc;
            cfg_async   = asy;
            cfg_base    = base;
            cfg_timeout = tmo;
            mod_ready   = hold_low ? 1'b0 : ($urandom_range(99) < rdy_pct);
            mod_rdata   = (midx < len) ? pat(seed, midx)
                                       : (esum ^ (corrupt ? 16'h0100 : 16'h0000));
            hs_out_ready = ($urandom_range(99) < ordy_pct);
            hs_in_valid  = (iidx < len) && ($urandom_range(99) < ival_pct);
            hs_in_data   = pat(seed, iidx);
            #1;
            if (c == 1) flags_c1 = err_cfg | err_cksum | err_timeout;
            if (c >= 1 && !done && !busy) busy_bad++;
            if (dir && ((mod_strobe && !mod_cksum) != (hs_in_valid && hs_in_ready))) data_bad++;
            if (mod_strobe) begin
                if (asy && !mod_ready) nrdy++;
                if (mod_addr != (inc ? 5'(base + 5'(midx)) : base)) addr_bad++;
                if (midx < len) begin
                    if (mod_cksum) cks_bad++;
                    if (dir && mod_wdata != pat(seed, midx)) data_bad++;
                end else begin
                    if (!mod_cksum) cks_bad++;
                    if (dir && mod_wdata != esum) cks_bad++;
                end
                if (first_s < 0) first_s = c;
                last_s = c;
                midx++;
            end
            if (hs_out_valid && hs_out_ready) begin
                if (hs_out_data != pat(seed, oidx)) data_bad++;
                oidx++;
            end
            if (hs_in_valid && hs_in_ready) iidx++;
            if (done) begin
                done_cnt++;
                done_cyc = c;
                break;
            end
        end
        start = 1'b0;
        check(done_cnt == 1, "R11", "done pulse count", done_cnt, 1);
        check(busy_bad == 0, "R1", "busy dropped early", busy_bad, 0);
        check(flags_c1 == 1'b0, "R12", "flags after start", flags_c1, 0);
        if (hold_low) begin
            check(err_timeout == 1'b1, "R10", "timeout flag", err_timeout, 1);
            check(midx == 0, "R10", "strobes while ready low", midx, 0);
            check(done_cyc == int'(tmo) + 2, "R10", "done cycle", done_cyc, int'(tmo) + 2);
            return;
        end
        check(midx == len + 1, "R1", "words strobed", midx, len + 1);
        check(addr_bad == 0, "R3", "address mismatches", addr_bad, 0);
        check(err_timeout == 1'b0, "R10", "spurious timeout", err_timeout, 0);
        if (asy) check(nrdy == 0, "R4", "strobes without ready", nrdy, 0);
        if (!asy && ordy_pct >= 100 && ival_pct >= 100)
            check(last_s - first_s == len, "R5", "strobe span", last_s - first_s, len);
        if (!dir) begin
            check(oidx == len, "R6", "host words at done", oidx, len);
            check(data_bad == 0, "R6", "host word mismatches", data_bad, 0);
            check(err_cksum == corrupt, "R8", "checksum flag", err_cksum, corrupt);
        end else begin
            check(iidx == len, "R7", "host words accepted", iidx, len);
            check(data_bad == 0, "R7", "module word mismatches", data_bad, 0);
            check(cks_bad == 0, "R9", "checksum word errors", cks_bad, 0);
        end
    endtask

    // A zero-length start: no busy, no strobe, no done, err_cfg raised.
    task automatic run_zero_len();
        int bad = 0;
        for (int c = 0; c < 6; c++) begin
            @(negedge clk);
            start   = (c == 0);
            cfg_len = '0;
            #1;
            if (c >= 1 && (busy || mod_strobe || done)) bad++;
        end
        start = 1'b0;
        check(bad == 0, "R2", "activity on zero length", bad, 0);
        check(err_cfg == 1'b1, "R2", "config error flag", err_cfg, 1);
        check(err_cfg == 1'b1, "R12", "config error still held", err_cfg, 1);
    endtask

    initial begin
        #1600000;
        n_fail++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
        summary();
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(!busy && !done && !mod_strobe && !hs_out_valid, "R1", "reset outputs quiet",
              {busy, done, mod_strobe, hs_out_valid}, 0);
        check(!err_cfg && !err_cksum && !err_timeout, "R12", "reset error flags",
              {err_cfg, err_cksum, err_timeout}, 0);
        // Directed corner cases
        run_xfer(12, 0, 1, 0, 5'd3,  8'd40, 16'h11, 0, 100, 100, 100, 0, 0); // R5 sync read
        run_xfer(9,  1, 1, 0, 5'd7,  8'd40, 16'h22, 0, 100, 100, 100, 0, 0); // R5 R9 sync write
        run_xfer(10, 0, 0, 1, 5'd9,  8'd40, 16'h33, 0, 50,  60,  100, 0, 0); // R3 fixed addr, R4
        run_xfer(8,  1, 0, 1, 5'd2,  8'd40, 16'h44, 0, 50,  100, 60,  0, 0); // R7 async write
        run_xfer(6,  0, 1, 1, 5'd0,  8'd40, 16'h55, 1, 70,  50,  100, 0, 0); // R8 bad checksum
        run_xfer(5,  0, 1, 0, 5'd30, 8'd40, 16'h66, 0, 100, 40,  100, 0, 0); // R3 wrap, R6 stall
        run_xfer(7,  0, 1, 1, 5'd4,  8'd6,  16'h77, 0, 0,   100, 100, 1, 0); // R10 read
        run_xfer(7,  1, 1, 1, 5'd4,  8'd3,  16'h78, 0, 0,   100, 100, 1, 0); // R10 write
        run_zero_len();                                                      // R2
        run_xfer(1,  0, 1, 0, 5'd1,  8'd40, 16'h88, 0, 100, 100, 100, 0, 0); // R12 clears
        run_xfer(15, 0, 1, 1, 5'd12, 8'd40, 16'h99, 0, 60,  70,  100, 0, 1); // R1 start while busy
        // Constrained random transfers
        for (int k = 0; k < 24; k++) begin
            bit d = 1'($urandom_range(1));
            run_xfer(int'($urandom_range(40, 1)), d, 1'($urandom_range(1)),
                     1'($urandom_range(1)), 5'($urandom_range(31)), 8'd40,
                     16'($urandom), d ? 1'b0 : 1'($urandom_range(1)),
                     int'($urandom_range(100, 30)), int'($urandom_range(100, 30)),
                     int'($urandom_range(100, 30)), 0, 0);
        end
        summary();
    end
endmodule